// File: doc/BRIEF.md
# Shared-Multiplier PWM Duty/Period Scaler

This block turns the signed fixed-point result of a control loop into two timing values for a pulse-width modulator: a duty time and a period time. A single multiplier is used twice per request. The first pass scales the loop value by an operand picked for duty. The second pass scales the same loop value by an operand picked for period. Both products go through the same sign-clamp and rounding step. After that the two results are handled differently. The duty result is limited by a programmable high bound and a programmable low bound, and it keeps four fractional bits. The period result has no bounds, and its fractional bits are dropped.

The loop value is a 24-bit signed fraction in S0.23 format. Each scale operand is a 14-bit unsigned integer, taken from a bank of four. A one-cycle start pulse launches the two passes. Each output register loads only when its own pass finishes, and it signals this with a one-cycle strobe. A busy flag covers the whole sequence.

Top module: `pwm_scaler`

## Requirements
- R1: While reset is high and after it is released, `duty_out` and `period_out` are zero, and `duty_vld`, `period_vld` and `busy` are low.
- R2: A negative product (loop value times operand) is treated as zero before rounding. The duty result then equals the low clamp, and the period result is zero.
- R3: The non-negative 37-bit magnitude is rounded to 18 bits by taking bits [36:19] and adding bit 18. If that addition carries out, the result saturates at all ones.
- R4: During the duty pass the operand is bank entry `duty_sel` (0 to 3). Entry k occupies `scale_bank[14k+13:14k]`. During the period pass the operand is bank entry 0 or 1, picked by `per_sel`.
- R5: The duty output is the rounded value limited to the range [`clamp_lo`, `clamp_hi`]. It is an 18-bit 14.4 value.
- R6: When `clamp_lo` is greater than `clamp_hi`, the duty output equals `clamp_hi`.
- R7: The period output is bits [17:4] of the rounded value, with no clamping.
- R8: Call N the rising edge at which a start is accepted. `duty_out` updates at edge N+2, and `duty_vld` is high for exactly the cycle that follows. `period_out` updates at edge N+3, and `period_vld` is high for the cycle that follows.
- R9: `busy` is high from edge N until edge N+3. A start that arrives while `busy` is high is ignored and produces no additional results.
- R10: Between their strobes, `duty_out` and `period_out` hold their values, even when the clamps or select inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a duty-then-period sequence when the block is idle |
| loop_in | input | 24 | Signed S0.23 control-loop result, captured on an accepted start |
| scale_bank | input | 56 | Four 14-bit unsigned scale operands, entry k at bits [14k+13:14k] |
| duty_sel | input | 2 | Bank entry used by the duty pass |
| per_sel | input | 1 | Bank entry (0 or 1) used by the period pass |
| clamp_hi | input | 18 | Upper bound for the duty result |
| clamp_lo | input | 18 | Lower bound for the duty result |
| duty_out | output | 18 | Duty time, 14.4 fixed point |
| duty_vld | output | 1 | One-cycle strobe when `duty_out` has been updated |
| period_out | output | 14 | Period time, integer ticks |
| period_vld | output | 1 | One-cycle strobe when `period_out` has been updated |
| busy | output | 1 | High while a sequence is running |

## Verification
The duty result falls due one cycle after edge N+2 and the period result one cycle after edge N+3, where N is the edge that accepts the start. The driver counts falling edges from the start and samples the strobes and busy at exactly those points. A separate scoreboard monitor compares every duty or period strobe against the front of its expected queue. Any strobe that arrives with an empty queue is reported, which is how a start issued during busy is shown to produce nothing.

// File: rtl/pwm_scaler_pkg.sv
package pwm_scaler_pkg;

    localparam int IN_W_DEF      = 24;
    localparam int OP_W_DEF      = 14;
    localparam int OUT_W_DEF     = 18;
    localparam int FRAC_W_DEF    = 4;
    localparam int DUTY_CAND_DEF = 4;
    localparam int PER_CAND_DEF  = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_DUTY   = 2'd1,
        SEQ_PERIOD = 2'd2,
        SEQ_FLUSH  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic load_in;      // capture loop value
        logic pass_period;  // operand mux picks the period candidate
        logic mul_en;       // multiplier register loads
        logic wr_duty;      // duty output register loads
        logic wr_period;    // period output register loads
    } seq_ctrl_t;

endpackage

// File: rtl/pwm_scaler_seq.sv
module pwm_scaler_seq
    import pwm_scaler_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output seq_ctrl_t ctrl,
    output logic      busy
);

    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE:   if (start) state_q <= SEQ_DUTY;
                SEQ_DUTY:   state_q <= SEQ_PERIOD;
                SEQ_PERIOD: state_q <= SEQ_FLUSH;
                SEQ_FLUSH:  state_q <= SEQ_IDLE;
                default:    state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ctrl.load_in     = (state_q == SEQ_IDLE) && start;
        ctrl.pass_period = (state_q == SEQ_PERIOD);
        ctrl.mul_en      = (state_q == SEQ_DUTY) || (state_q == SEQ_PERIOD);
        ctrl.wr_duty     = (state_q == SEQ_PERIOD);
        ctrl.wr_period   = (state_q == SEQ_FLUSH);
        busy             = (state_q != SEQ_IDLE);
    end

endmodule

// File: rtl/pwm_scaler_opsel.sv
module pwm_scaler_opsel #(
    parameter int OP_W      = pwm_scaler_pkg::OP_W_DEF,
    parameter int DUTY_CAND = pwm_scaler_pkg::DUTY_CAND_DEF,
    parameter int PER_CAND  = pwm_scaler_pkg::PER_CAND_DEF,
    localparam int DSEL_W   = (DUTY_CAND > 1) ? $clog2(DUTY_CAND) : 1,
    localparam int PSEL_W   = (PER_CAND > 1) ? $clog2(PER_CAND) : 1
) (
    input  logic [DUTY_CAND*OP_W-1:0] bank,
    input  logic [DSEL_W-1:0]         duty_sel,
    input  logic [PSEL_W-1:0]         per_sel,
    input  logic                      pass_period,
    output logic [OP_W-1:0]           operand
);

    logic [OP_W-1:0] cand [DUTY_CAND];
    logic [OP_W-1:0] duty_op;
    logic [OP_W-1:0] per_op;

    for (genvar k = 0; k < DUTY_CAND; k++) begin : g_unpack
        assign cand[k] = bank[k*OP_W +: OP_W];
    end

    // Period candidates are the lowest PER_CAND bank entries.
    always_comb begin
        duty_op = cand[duty_sel];
        per_op  = '0;
        for (int k = 0; k < PER_CAND; k++) begin
            if (per_sel == PSEL_W'(k)) per_op = cand[k];
        end
        operand = pass_period ? per_op : duty_op;
    end

endmodule

// File: rtl/pwm_scaler_mult.sv
module pwm_scaler_mult #(
    parameter int IN_W   = pwm_scaler_pkg::IN_W_DEF,
    parameter int OP_W   = pwm_scaler_pkg::OP_W_DEF,
    localparam int PROD_W = IN_W + OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [IN_W-1:0]   a,
    input  logic [OP_W-1:0]   op,
    output logic [PROD_W-1:0] prod
);

    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] op_ext;
    logic signed [PROD_W-1:0] full;

    always_comb begin
        a_ext  = {{OP_W{a[IN_W-1]}}, a};
        op_ext = {{IN_W{1'b0}}, op};
        full   = a_ext * op_ext;
    end

    always_ff @(posedge clk) begin
        if (rst)     prod <= '0;
        else if (en) prod <= full;
    end

endmodule

// File: rtl/pwm_scaler_post.sv
module pwm_scaler_post #(
    parameter int PROD_W = pwm_scaler_pkg::IN_W_DEF + pwm_scaler_pkg::OP_W_DEF,
    parameter int OUT_W  = pwm_scaler_pkg::OUT_W_DEF,
    parameter int FRAC_W = pwm_scaler_pkg::FRAC_W_DEF,
    localparam int MAG_W = PROD_W - 1,
    localparam int DROP  = MAG_W - OUT_W,
    localparam int PER_W = OUT_W - FRAC_W
) (
    input  logic [PROD_W-1:0] prod,
    input  logic [OUT_W-1:0]  clamp_hi,
    input  logic [OUT_W-1:0]  clamp_lo,
    output logic [OUT_W-1:0]  duty,
    output logic [PER_W-1:0]  period
);

    logic [MAG_W-1:0] mag;
    logic [OUT_W:0]   sum;
    logic [OUT_W-1:0] rnd;
    logic [OUT_W-1:0] floored;

    always_comb begin
        mag     = prod[PROD_W-1] ? '0 : prod[MAG_W-1:0];
        sum     = {1'b0, mag[MAG_W-1:DROP]} + (OUT_W+1)'(mag[DROP-1]);
        rnd     = sum[OUT_W] ? '1 : sum[OUT_W-1:0];
        // Apply the low bound first so the high bound wins on inversion.
        floored = (rnd < clamp_lo) ? clamp_lo : rnd;
        duty    = (floored > clamp_hi) ? clamp_hi : floored;
        period  = rnd[OUT_W-1:FRAC_W];
    end

endmodule

// File: rtl/pwm_scaler.sv
module pwm_scaler
    import pwm_scaler_pkg::*;
#(
    parameter int IN_W      = IN_W_DEF,
    parameter int OP_W      = OP_W_DEF,
    parameter int OUT_W     = OUT_W_DEF,
    parameter int FRAC_W    = FRAC_W_DEF,
    parameter int DUTY_CAND = DUTY_CAND_DEF,
    parameter int PER_CAND  = PER_CAND_DEF,
    localparam int PROD_W   = IN_W + OP_W,
    localparam int PER_W    = OUT_W - FRAC_W,
    localparam int DSEL_W   = (DUTY_CAND > 1) ? $clog2(DUTY_CAND) : 1,
    localparam int PSEL_W   = (PER_CAND > 1) ? $clog2(PER_CAND) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [IN_W-1:0]           loop_in,
    input  logic [DUTY_CAND*OP_W-1:0] scale_bank,
    input  logic [DSEL_W-1:0]         duty_sel,
    input  logic [PSEL_W-1:0]         per_sel,
    input  logic [OUT_W-1:0]          clamp_hi,
    input  logic [OUT_W-1:0]          clamp_lo,
    output logic [OUT_W-1:0]          duty_out,
    output logic                      duty_vld,
    output logic [PER_W-1:0]          period_out,
    output logic                      period_vld,
    output logic                      busy
);

    seq_ctrl_t         ctrl;
    logic [IN_W-1:0]   loop_q;
    logic [OP_W-1:0]   operand;
    logic [PROD_W-1:0] prod;
    logic [OUT_W-1:0]  duty_c;
    logic [PER_W-1:0]  period_c;

    pwm_scaler_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst)               loop_q <= '0;
        else if (ctrl.load_in) loop_q <= loop_in;
    end

    pwm_scaler_opsel #(
        .OP_W      (OP_W),
        .DUTY_CAND (DUTY_CAND),
        .PER_CAND  (PER_CAND)
    ) u_opsel (
        .bank        (scale_bank),
        .duty_sel    (duty_sel),
        .per_sel     (per_sel),
        .pass_period (ctrl.pass_period),
        .operand     (operand)
    );

    pwm_scaler_mult #(
        .IN_W (IN_W),
        .OP_W (OP_W)
    ) u_mult (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl.mul_en),
        .a    (loop_q),
        .op   (operand),
        .prod (prod)
    );

    pwm_scaler_post #(
        .PROD_W (PROD_W),
        .OUT_W  (OUT_W),
        .FRAC_W (FRAC_W)
    ) u_post (
        .prod     (prod),
        .clamp_hi (clamp_hi),
        .clamp_lo (clamp_lo),
        .duty     (duty_c),
        .period   (period_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_out   <= '0;
            duty_vld   <= 1'b0;
            period_out <= '0;
            period_vld <= 1'b0;
        end else begin
            duty_vld   <= ctrl.wr_duty;
            period_vld <= ctrl.wr_period;
            if (ctrl.wr_duty)   duty_out   <= duty_c;
            if (ctrl.wr_period) period_out <= period_c;
        end
    end

endmodule

// File: rtl/pwm_scaler_chk.sv
module pwm_scaler_chk #(
    parameter int OUT_W = 18,
    parameter int PER_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [OUT_W-1:0] clamp_hi,
    input logic [OUT_W-1:0] clamp_lo,
    input logic [OUT_W-1:0] duty_out,
    input logic             duty_vld,
    input logic [PER_W-1:0] period_out,
    input logic             period_vld,
    input logic             busy
);

    assert_clamp_hi_R5: assert property (@(posedge clk) disable iff (rst)
        duty_vld |-> duty_out <= $past(clamp_hi));

    assert_clamp_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (duty_vld && $past(clamp_lo) <= $past(clamp_hi)) |-> duty_out >= $past(clamp_lo));

    assert_inverted_R6: assert property (@(posedge clk) disable iff (rst)
        (duty_vld && $past(clamp_lo) > $past(clamp_hi)) |-> duty_out == $past(clamp_hi));

    assert_order_R8: assert property (@(posedge clk) disable iff (rst)
        duty_vld |=> period_vld);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({duty_vld, period_vld}));

    assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
        period_vld |-> !busy);

    assert_duty_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !duty_vld |-> $stable(duty_out));

    assert_period_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !period_vld |-> $stable(period_out));

endmodule

bind pwm_scaler pwm_scaler_chk #(
    .OUT_W (OUT_W),
    .PER_W (PER_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .clamp_hi   (clamp_hi),
    .clamp_lo   (clamp_lo),
    .duty_out   (duty_out),
    .duty_vld   (duty_vld),
    .period_out (period_out),
    .period_vld (period_vld),
    .busy       (busy)
);

// File: tb/pwm_scaler_tb_top.sv
module pwm_scaler_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] loop_in = '0;
    logic [55:0] scale_bank = '0;
    logic [1:0]  duty_sel = '0;
    logic [0:0]  per_sel = '0;
    logic [17:0] clamp_hi = '1;
    logic [17:0] clamp_lo = '0;
    logic [17:0] duty_out;
    logic        duty_vld;
    logic [13:0] period_out;
    logic        period_vld;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    logic [17:0] duty_q [$];
    logic [13:0] per_q  [$];

    always #10 clk = ~clk;

    pwm_scaler dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .loop_in    (loop_in),
        .scale_bank (scale_bank),
        .duty_sel   (duty_sel),
        .per_sel    (per_sel),
        .clamp_hi   (clamp_hi),
        .clamp_lo   (clamp_lo),
        .duty_out   (duty_out),
        .duty_vld   (duty_vld),
        .period_out (period_out),
        .period_vld (period_vld),
        .busy       (busy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference from the requirements: negative -> 0 (R2), round (R3).
    function automatic longint rounded(input logic [23:0] lv, input logic [13:0] op);
        longint p, r;
        p = longint'($signed(lv)) * longint'(op);
        if (p < 0) p = 0;
        r = (p >>> 19) + ((p >>> 18) & 1);
        if (r > 262143) r = 262143;
        return r;
    endfunction

    function automatic logic [13:0] bank_op(input int k);
        return scale_bank[k*14 +: 14];
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (duty_vld) begin
                if (duty_q.size() == 0) check(1'b0, "R9 unexpected duty", duty_out, 0);
                else begin
                    logic [17:0] e;
                    e = duty_q.pop_front();
                    check(duty_out == e, "R5 duty value", duty_out, e);
                end
            end
            if (period_vld) begin
                if (per_q.size() == 0) check(1'b0, "R9 unexpected period", period_out, 0);
                else begin
                    logic [13:0] e;
                    e = per_q.pop_front();
                    check(period_out == e, "R7 period value", period_out, e);
                end
            end
        end
    end

    task automatic run(input logic [23:0] lv, input logic [1:0] ds, input logic pz,
                       input logic [17:0] hi, input logic [17:0] lo, input bit stray);
        longint rd, rp, d;
        @(negedge clk);
        loop_in  = lv;
        duty_sel = ds;
        per_sel  = pz;
        clamp_hi = hi;
        clamp_lo = lo;
        rd = rounded(lv, bank_op(int'(ds)));
        rp = rounded(lv, bank_op(int'(pz)));
        d  = (rd < longint'(lo)) ? longint'(lo) : rd;
        if (d > longint'(hi)) d = longint'(hi);
        duty_q.push_back(18'(d));
        per_q.push_back(14'(rp >>> 4));
        start = 1'b1;
        @(negedge clk);                    // edge N passed
        start = stray ? 1'b1 : 1'b0;
        loop_in = ~lv;                      // captured value must be used
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        @(negedge clk);                    // edge N+1
        start = 1'b0;
        check(duty_vld == 1'b0, "R8 duty not early", duty_vld, 0);
        @(negedge clk);                    // edge N+2
        check(duty_vld == 1'b1, "R8 duty strobe", duty_vld, 1);
        check(busy == 1'b1, "R9 busy mid", busy, 1);
        @(negedge clk);                    // edge N+3
        check(period_vld == 1'b1, "R8 period strobe", period_vld, 1);
        check(busy == 1'b0, "R9 busy end", busy, 0);
        @(negedge clk);
        check(period_vld == 1'b0, "R8 period one cycle", period_vld, 0);
        if (stray) begin
            repeat (4) @(negedge clk);
            check(!busy && !duty_vld && !period_vld, "R9 stray start ignored", busy, 0);
        end
    endtask

    initial begin
        scale_bank = {14'd300, 14'h3FFF, 14'd2500, 14'd1001}; // entries 3..0
        repeat (3) @(negedge clk);
        check(duty_out == 0 && period_out == 0, "R1 outputs zero in reset", duty_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check(duty_out == 0 && period_out == 0, "R1 outputs zero", period_out, 0);
        check(!duty_vld && !period_vld && !busy, "R1 strobes low", busy, 0);

        run(24'h400000, 2'd1, 1'b0, 18'h3FFFF, 18'd0, 1'b0);   // R4 entry1 duty
        run(24'h0C0000, 2'd0, 1'b0, 18'h3FFFF, 18'd0, 1'b0);   // R3 1501.5 -> 1502
        check(duty_out == 18'd1502, "R3 round up", duty_out, 1502);
        run(24'h800000, 2'd2, 1'b1, 18'h3FFFF, 18'd0, 1'b0);   // R2 negative -> 0
        check(period_out == 0, "R2 negative period", period_out, 0);
        run(24'hC00000, 2'd1, 1'b0, 18'h3FFFF, 18'd100, 1'b0); // R2 -> low clamp
        check(duty_out == 18'd100, "R2 low clamp", duty_out, 100);
        run(24'h7FFFFF, 2'd2, 1'b1, 18'd5000, 18'd0, 1'b0);    // R5 high clamp
        check(duty_out == 18'd5000, "R5 high clamp", duty_out, 5000);
        run(24'h200000, 2'd3, 1'b0, 18'd4000, 18'd9000, 1'b0); // R6 inverted
        check(duty_out == 18'd4000, "R6 high wins", duty_out, 4000);
        run(24'h600000, 2'd0, 1'b1, 18'd10, 18'd0, 1'b0);      // R7 unclamped
        run(24'h123456, 2'd3, 1'b1, 18'h3FFFF, 18'd0, 1'b1);   // R9 stray start

        // R10: change clamps and selects, outputs must hold
        begin
            logic [17:0] dh;
            logic [13:0] ph;
            dh = duty_out;
            ph = period_out;
            clamp_hi = 18'd1;
            clamp_lo = 18'd0;
            duty_sel = 2'd2;
            per_sel  = 1'b1;
            repeat (5) @(negedge clk);
            check(duty_out == dh, "R10 duty hold", duty_out, dh);
            check(period_out == ph, "R10 period hold", period_out, ph);
        end

        check(duty_q.size() == 0 && per_q.size() == 0, "R8 all results seen",
              duty_q.size() + per_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule